// File: doc/BRIEF.md
# GPIO Port Register Slice with Configuration Lock

This block is the register slice of one 16-pin general-purpose I/O port. Software reaches it over a simple synchronous bus and reads back through a registered read port. It holds two 32-bit configuration words with one 4-bit field per pin: pins 0 to 7 sit in the low word and pins 8 to 15 in the high word. It also holds a 16-bit output data word, a write-only bit-clear port, and a lock register. The configuration words and the output data go straight to the pad logic.

The lock register holds a 16-bit pin selection and a key bit. A lock engages only after three full-word writes to the lock register in a fixed order: key 1, then key 0, then key 1, all with the same pin selection. From then on, the configuration fields of the selected pins ignore writes until the next reset. The key sequence state machine has these states. LK_IDLE waits for the first key-1 write and moves to LK_ARM1. LK_ARM1 moves to LK_ARM0 on a key-0 write with the same selection. LK_ARM0 moves to LK_SET on a key-1 write with the same selection. In LK_SET the lock is active, and a read moves it to LK_CHK. In LK_CHK a read moves it to LK_HELD. LK_HELD keeps the lock until reset. Any other lock write in LK_ARM1 or LK_ARM0 sends the machine back to LK_IDLE.

Top module: `gpio_lock_regs`

## Requirements
- R1: After reset, both configuration words, the output data, the lock selection and the key read as zero, and no pin is locked.
- R2: Configuration words sit at byte offset 0x00 (pins 0-7, pin n in bits 4n+3:4n) and 0x04 (pins 8-15, pin n in bits 4(n-8)+3:4(n-8)). Each byte strobe bus_be[b] enables write data bits 8b+7:8b. A read with bus_re returns the word on bus_rdata after the next clock edge, and bus_rdata is zero in any cycle that follows no read.
- R3: Output data sits at offset 0x0C in bits 15:0 and is written under byte strobes. Bits 31:16 read as zero.
- R4: A write to offset 0x14 with all four byte strobes set clears each output data bit whose write data bit (15:0) is 1 and keeps the others. Reads of 0x14 return zero.
- R5: A write to offset 0x14 without all four byte strobes set leaves the output data unchanged.
- R6: The lock register at offset 0x18 holds the pin selection in bits 15:0 and the key in bit 16. Bits 31:17 read as zero. Only writes with all four byte strobes set change it, and before a lock it reads back the last accepted value.
- R7: The writes key=1, key=0, key=1 (bit 16) to 0x18 with equal bits 15:0 lock the selected pins from the third write onward.
- R8: In LK_ARM1 or LK_ARM0, a lock write with the wrong key or a changed selection returns the machine to LK_IDLE, so no lock engages before a fresh three-write sequence.
- R9: Once locked, the first read of 0x18 returns key 0, and every later read returns key 1. Bits 15:0 return the locked selection.
- R10: While locked, a configuration write changes only the 4-bit fields of unselected pins. Locked fields keep their contents.
- R11: While locked, lock-register writes, including writes of zero and new key sequences, have no effect. The lock persists until reset, and reset releases it.
- R12: While locked, output data writes and bit-clear writes keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_be | input | DATA_W/8 | Byte strobes for writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cfg_lo | output | DATA_W | Configuration of pins 0-7 to the pads |
| cfg_hi | output | DATA_W | Configuration of pins 8-15 to the pads |
| out_data | output | NUM_PINS | Output data to the pads |

## Verification
Every write is captured on the clock edge that samples it, so its effect on cfg_lo, cfg_hi, out_data and the lock state is due one cycle after the stimulus is driven. Read data is due one edge after the read strobe. The driver applies stimulus just after a rising edge, and the bench checks pad outputs only after the capturing edge has passed. For each read the driver queues the expected word, and a monitor compares bus_rdata on the falling edge of the following cycle. The lock sequence checks sample the key bit read by read, because each read of the lock register advances the state machine.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_CFG_LO = 8'h00;
    localparam logic [7:0] OFS_CFG_HI = 8'h04;
    localparam logic [7:0] OFS_OUT    = 8'h0C;
    localparam logic [7:0] OFS_CLR    = 8'h14;
    localparam logic [7:0] OFS_LOCK   = 8'h18;

    // Key sequence states
    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ARM1,
        LK_ARM0,
        LK_SET,
        LK_CHK,
        LK_HELD
    } lock_state_t;

endpackage

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
    import gpio_lock_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                key_in,
    input  logic [NUM_PINS-1:0] sel_in,
    output logic [NUM_PINS-1:0] sel_q,
    output logic                lock_active,
    output logic                key_rd
);

    lock_state_t         state_q, state_d;
    logic [NUM_PINS-1:0] sel_d;
    logic                key_q, key_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            sel_q   <= '0;
            key_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            key_q   <= key_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        lock_active = 1'b0;
        key_rd      = key_q;
        unique case (state_q)
            LK_IDLE: begin
                if (wr_en && key_in) state_d = LK_ARM1;
            end
            LK_ARM1: begin
                if (wr_en)
                    state_d = (!key_in && sel_in == sel_q) ? LK_ARM0 : LK_IDLE;
            end
            LK_ARM0: begin
                if (wr_en)
                    state_d = (key_in && sel_in == sel_q) ? LK_SET : LK_IDLE;
            end
            LK_SET: begin
                lock_active = 1'b1;
                key_rd      = 1'b0;
                if (rd_en) state_d = LK_CHK;
            end
            LK_CHK: begin
                lock_active = 1'b1;
                key_rd      = 1'b1;
                if (rd_en) state_d = LK_HELD;
            end
            LK_HELD: begin
                lock_active = 1'b1;
                key_rd      = 1'b1;
            end
            default: state_d = LK_IDLE;
        endcase

        sel_d = sel_q;
        key_d = key_q;
        if (wr_en && !lock_active) begin
            sel_d = sel_in;
            key_d = key_in;
        end
    end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [DATA_W/8-1:0]    be,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [DATA_W/FIELD_W-1:0] freeze,
    output logic [DATA_W-1:0]      q
);

    localparam int FIELDS = DATA_W / FIELD_W;

    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        localparam int BYTE_IDX = (f * FIELD_W) / 8;
        logic [FIELD_W-1:0] fld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fld_q <= '0;
            else if (wr_en && be[BYTE_IDX] && !freeze[f])
                fld_q <= wdata[f*FIELD_W +: FIELD_W];
        end

        assign q[f*FIELD_W +: FIELD_W] = fld_q;
    end

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
    parameter int NUM_PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NUM_PINS/8-1:0] be,
    input  logic [NUM_PINS-1:0]   wdata,
    input  logic                  clr_en,
    input  logic [NUM_PINS-1:0]   clr_mask,
    output logic [NUM_PINS-1:0]   q
);

    localparam int NBYTES = NUM_PINS / 8;

    logic [NUM_PINS-1:0] q_d;

    always_comb begin
        q_d = q;
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++)
                if (be[b]) q_d[b*8 +: 8] = wdata[b*8 +: 8];
        end else if (clr_en) begin
            q_d = q & ~clr_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

endmodule

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs
    import gpio_lock_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [DATA_W-1:0]   cfg_lo,
    output logic [DATA_W-1:0]   cfg_hi,
    output logic [NUM_PINS-1:0] out_data
);

    localparam int FIELDS  = NUM_PINS / 2;
    localparam int FIELD_W = DATA_W / FIELDS;
    localparam int KEY_BIT = NUM_PINS;

    logic hit_lo, hit_hi, hit_out, hit_clr, hit_lock, full_word;
    logic                lock_active, key_rd;
    logic [NUM_PINS-1:0] lock_sel;
    logic [FIELDS-1:0]   freeze_lo, freeze_hi;
    logic [DATA_W-1:0]   rd_mux;

    assign hit_lo    = (bus_addr == OFS_CFG_LO[ADDR_W-1:0]);
    assign hit_hi    = (bus_addr == OFS_CFG_HI[ADDR_W-1:0]);
    assign hit_out   = (bus_addr == OFS_OUT[ADDR_W-1:0]);
    assign hit_clr   = (bus_addr == OFS_CLR[ADDR_W-1:0]);
    assign hit_lock  = (bus_addr == OFS_LOCK[ADDR_W-1:0]);
    assign full_word = &bus_be;

    assign freeze_lo = lock_active ? lock_sel[FIELDS-1:0]        : '0;
    assign freeze_hi = lock_active ? lock_sel[NUM_PINS-1:FIELDS] : '0;

    gpio_lock_seq #(.NUM_PINS(NUM_PINS)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_we && hit_lock && full_word),
        .rd_en       (bus_re && hit_lock),
        .key_in      (bus_wdata[KEY_BIT]),
        .sel_in      (bus_wdata[NUM_PINS-1:0]),
        .sel_q       (lock_sel),
        .lock_active (lock_active),
        .key_rd      (key_rd)
    );

    gpio_cfg_bank #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) cfg_lo_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we && hit_lo),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .freeze (freeze_lo),
        .q      (cfg_lo)
    );

    gpio_cfg_bank #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) cfg_hi_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we && hit_hi),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .freeze (freeze_hi),
        .q      (cfg_hi)
    );

    gpio_out_reg #(.NUM_PINS(NUM_PINS)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && hit_out),
        .be       (bus_be[NUM_PINS/8-1:0]),
        .wdata    (bus_wdata[NUM_PINS-1:0]),
        .clr_en   (bus_we && hit_clr && full_word),
        .clr_mask (bus_wdata[NUM_PINS-1:0]),
        .q        (out_data)
    );

    // Read multiplexer; the bit-clear port always reads zero
    always_comb begin
        rd_mux = '0;
        if (hit_lo) begin
            rd_mux = cfg_lo;
        end else if (hit_hi) begin
            rd_mux = cfg_hi;
        end else if (hit_out) begin
            rd_mux[NUM_PINS-1:0] = out_data;
        end else if (hit_lock) begin
            rd_mux[NUM_PINS-1:0] = lock_sel;
            rd_mux[KEY_BIT]      = key_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/gpio_lock_regs_chk.sv
module gpio_lock_regs_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic                bus_re,
    input logic [DATA_W/8-1:0] bus_be,
    input logic [NUM_PINS-1:0] clr_data,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [DATA_W-1:0]   cfg_lo,
    input logic [DATA_W-1:0]   cfg_hi,
    input logic [NUM_PINS-1:0] out_data,
    input logic                lock_active,
    input logic [NUM_PINS-1:0] lock_sel
);

    localparam int FIELDS  = NUM_PINS / 2;
    localparam int FIELD_W = DATA_W / FIELDS;
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(8'h14);

    logic [DATA_W-1:0] lo_exp, hi_exp;

    always_comb begin
        for (int f = 0; f < FIELDS; f++) begin
            lo_exp[f*FIELD_W +: FIELD_W] = {FIELD_W{lock_sel[f]}};
            hi_exp[f*FIELD_W +: FIELD_W] = {FIELD_W{lock_sel[FIELDS+f]}};
        end
    end

    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CLR_ADDR && &bus_be)
        |=> (out_data & $past(clr_data)) == '0);

    a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == CLR_ADDR) |=> bus_rdata == '0);

    a_r5_partial_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CLR_ADDR && !(&bus_be)) |=> $stable(out_data));

    a_r10_locked_lo_stable: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> ((cfg_lo ^ $past(cfg_lo)) & lo_exp) == '0);

    a_r10_locked_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> ((cfg_hi ^ $past(cfg_hi)) & hi_exp) == '0);

    a_r11_lock_persists: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> lock_active && $stable(lock_sel));

endmodule

bind gpio_lock_regs gpio_lock_regs_chk #(
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_be      (bus_be),
    .clr_data    (bus_wdata[NUM_PINS-1:0]),
    .bus_rdata   (bus_rdata),
    .cfg_lo      (cfg_lo),
    .cfg_hi      (cfg_hi),
    .out_data    (out_data),
    .lock_active (lock_active),
    .lock_sel    (lock_sel)
);

// File: tb/gpio_lock_regs_tb_top.sv
module gpio_lock_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] cfg_lo, cfg_hi;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    bit re_d = 1'b0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // 20-unit period: 50 MHz with 1 ns units
    always #10 clk = ~clk;

    gpio_lock_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .out_data(out_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [3:0] be, logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_be = be; bus_wdata = d;
    endtask

    task automatic bus_read(logic [4:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = a; bus_be = '0; bus_wdata = '0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic bus_idle();
        @(posedge clk); #1;
        bus_we = 1'b0; bus_re = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    // Monitor: read data is due one edge after the read strobe
    always @(negedge clk) begin
        if (re_d) begin
            if (exp_q.size() == 0) begin
                check("unexpected read", bus_rdata, 32'hxxxx_xxxx);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
        re_d = bus_re && rst_n;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 cfg_lo", cfg_lo, 32'h0);
        check("R1 cfg_hi", cfg_hi, 32'h0);
        check("R1 out_data", {16'h0, out_data}, 32'h0);
        bus_read(5'h18, 32'h0, "R1 lock reg");
        bus_read(5'h00, 32'h0, "R1 cfg_lo read");

        // R2 configuration words, byte strobes
        bus_write(5'h00, 4'hF, 32'h1234_5678);
        bus_write(5'h04, 4'b0101, 32'hAABB_CCDD);
        bus_idle();
        check("R2 cfg_lo pads", cfg_lo, 32'h1234_5678);
        check("R2 cfg_hi byte strobes", cfg_hi, 32'h00BB_00DD);
        bus_read(5'h00, 32'h1234_5678, "R2 cfg_lo read");
        bus_read(5'h04, 32'h00BB_00DD, "R2 cfg_hi read");

        // R3 output data
        bus_write(5'h0C, 4'hF, 32'hFFFF_A5C3);
        bus_idle();
        check("R3 out full", {16'h0, out_data}, 32'h0000_A5C3);
        bus_read(5'h0C, 32'h0000_A5C3, "R3 out read upper zero");
        bus_write(5'h0C, 4'b0001, 32'h0000_0011);
        bus_idle();
        check("R3 out byte", {16'h0, out_data}, 32'h0000_A511);

        // R4 bit clear, R5 partial ignored
        bus_write(5'h14, 4'hF, 32'hFFFF_0101);
        bus_idle();
        check("R4 clear", {16'h0, out_data}, 32'h0000_A410);
        bus_read(5'h14, 32'h0, "R4 clear reads zero");
        bus_write(5'h14, 4'b0011, 32'h0000_FFFF);
        bus_idle();
        check("R5 partial clear", {16'h0, out_data}, 32'h0000_A410);

        // R6 lock register storage
        bus_write(5'h18, 4'hF, 32'hFFFF_0003);
        bus_read(5'h18, 32'h0001_0003, "R6 lock readback");
        bus_write(5'h18, 4'b0011, 32'h0);
        bus_read(5'h18, 32'h0001_0003, "R6 partial lock write ignored");
        bus_write(5'h18, 4'hF, 32'h0);
        bus_read(5'h18, 32'h0, "R6 lock cleared");

        // R8 broken sequences leave pins unlocked
        bus_write(5'h18, 4'hF, 32'h0001_0101);
        bus_write(5'h18, 4'hF, 32'h0001_0101);
        bus_write(5'h18, 4'hF, 32'h0000_0101);
        bus_write(5'h18, 4'hF, 32'h0001_0101);
        bus_write(5'h00, 4'hF, 32'hFFFF_FFFF);
        bus_idle();
        check("R8 wrong key no lock", cfg_lo, 32'hFFFF_FFFF);
        bus_write(5'h18, 4'hF, 32'h0000_0101);
        bus_write(5'h18, 4'hF, 32'h0001_0102);
        bus_write(5'h00, 4'hF, 32'h0);
        bus_idle();
        check("R8 changed mask no lock", cfg_lo, 32'h0);

        // R7 lock sequence on pins 0, 8, 15
        bus_write(5'h00, 4'hF, 32'h1111_1111);
        bus_write(5'h04, 4'hF, 32'h2222_2222);
        bus_write(5'h18, 4'hF, 32'h0001_8101);
        bus_write(5'h18, 4'hF, 32'h0000_8101);
        bus_write(5'h18, 4'hF, 32'h0001_8101);
        bus_write(5'h00, 4'hF, 32'h0);
        bus_idle();
        check("R7 lock engaged", cfg_lo, 32'h0000_0001);

        // R9 key readback sequence
        bus_read(5'h18, 32'h0000_8101, "R9 first read key 0");
        bus_read(5'h18, 32'h0001_8101, "R9 second read key 1");
        bus_read(5'h18, 32'h0001_8101, "R9 later read key 1");

        // R10 locked fields keep contents
        bus_write(5'h00, 4'hF, 32'hAAAA_AAAA);
        bus_write(5'h04, 4'hF, 32'h5555_5555);
        bus_idle();
        check("R10 cfg_lo pin0 locked", cfg_lo, 32'hAAAA_AAA1);
        check("R10 cfg_hi pin8 pin15 locked", cfg_hi, 32'h2555_5552);
        bus_write(5'h00, 4'b0001, 32'h0000_00FF);
        bus_idle();
        check("R10 byte write with lock", cfg_lo, 32'hAAAA_AAF1);

        // R11 lock register frozen
        bus_write(5'h18, 4'hF, 32'h0);
        bus_read(5'h18, 32'h0001_8101, "R11 clear ignored");
        bus_write(5'h18, 4'hF, 32'h0001_FFFF);
        bus_write(5'h18, 4'hF, 32'h0000_FFFF);
        bus_write(5'h18, 4'hF, 32'h0001_FFFF);
        bus_read(5'h18, 32'h0001_8101, "R11 new sequence ignored");
        bus_write(5'h00, 4'hF, 32'h0);
        bus_idle();
        check("R11 still locked", cfg_lo, 32'h0000_0001);

        // R12 output path unaffected by lock
        bus_write(5'h0C, 4'hF, 32'h0000_FFFF);
        bus_write(5'h14, 4'hF, 32'h0000_8001);
        bus_idle();
        check("R12 out after lock", {16'h0, out_data}, 32'h0000_7FFE);
        bus_read(5'h0C, 32'h0000_7FFE, "R12 out read");
        bus_idle();
        repeat (2) @(posedge clk);

        // R11 reset releases the lock
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 cfg_lo after reset", cfg_lo, 32'h0);
        bus_read(5'h18, 32'h0, "R11 lock gone after reset");
        bus_write(5'h00, 4'hF, 32'hFFFF_FFFF);
        bus_idle();
        check("R11 writes free after reset", cfg_lo, 32'hFFFF_FFFF);

        repeat (3) @(posedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule